// File: doc/BRIEF.md
# I2C Target Controller with CPU Register Port

This block is a 7-bit-address I2C target that sits on a 16-bit CPU register port. Software sets the target's own address and a control word, loads bytes for the controller to read, and reads back the last byte the controller wrote. The block matches the address and acknowledges it. It receives bytes with a programmable ACK or NAK and sends bytes MSB first. It can hold SCL low while it waits for software to supply a byte.

The transmit byte has a discard control. While the discard bit is set, any byte still pending is dropped. This stops a byte left over from an earlier transfer from going out in a new read transfer. Writes made in this state store data, but they do not mark a byte as pending. A software reset bit releases both bus lines and clears every other control bit. An optional input filter rejects bus glitches that last one system clock.

The register port selects a word with `bus_sel`. Word 0 is the own address. Word 1 is the control word. Word 2 is the transmit byte on write, and the status and received byte on read. Word 3 reads back the stored transmit byte. Reads are combinational.

Top module: `i2c_slave_port`

## Requirements
- R1: After reset, word 0 and word 1 read 0, word 2 reads 0x0100 (transmit-empty set, received byte 0), and neither `scl_oe` nor `sda_oe` is asserted.
- R2: Word 0 holds the address in bits 6:0, and bits 15:7 read 0. Word 1 holds these control bits: 8 discard, 7 enable, 6 soft reset, 5 NAK reply, 4 bus-free request enable, 3 clock stretch, 2 noise filter, 1 async address detection, 0 active mode. Bits 15:9 read 0. In word 2, bit 8 is transmit-empty and bits 7:0 are the last received byte.
- R3: With enable and active mode set, an address byte whose upper 7 bits equal the own address is ACKed. A mismatching address is NAKed, and the target ignores the bus until the next start or stop.
- R4: In standby mode (bit 0 = 0), a matching address is NAKed.
- R5: With enable at 0, the block never drives either line and ACKs nothing.
- R6: A received data byte is ACKed when NAK reply is 0 and NAKed when it is 1. The byte then appears in word 2 bits 7:0.
- R7: A write to word 2 with discard at 0 makes the byte pending and clears transmit-empty. When the byte is loaded for sending, transmit-empty is set, and the byte goes out MSB first.
- R8: With clock stretch on, a read phase with no pending byte holds SCL low until software writes word 2.
- R9: With clock stretch off, a read phase with no pending byte sends the current contents of the transmit byte.
- R10: Setting discard drops any pending byte. A word 2 write while discard is set leaves transmit-empty unchanged, and clearing discard does not clear transmit-empty either.
- R11: Writing word 1 with bit 6 set makes word 1 read 0x0040, releases both lines, and returns the target to waiting for a start. The own address is kept.
- R12: With the noise filter on, a one-clock SDA glitch while SCL is high is ignored. With the filter off, the same glitch is taken as a start and stop, and the transfer is aborted.
- R13: After the controller NAKs a transmitted byte, the target releases SDA and ignores clocks until a start or stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 2 | Register word select |
| bus_we | input | 1 | Register write strobe |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Register read data (combinational) |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
The hardest case to reach is a stale byte. A byte is still pending from an earlier write when a new read transfer selects the target, and the bench must show that the discard bit keeps that byte off the bus. The bench writes a byte and then toggles discard. It then starts a stretched read and checks that SCL stays low, which proves nothing was pending. Only after that does it write a fresh byte and check that this byte arrives. The noise-filter case is also hard to reach: the bench places a one-clock SDA pulse inside a high SCL phase, then runs the same transfer with the filter on and with it off.

// File: rtl/i2c_slave_port.sv
module i2c_slave_port (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  bus_sel,
  input  logic        bus_we,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        scl_oe,
  output logic        sda_oe
);
  localparam int CLR = 8, EN = 7, SRST = 6, NAKA = 5, STR = 3, NF = 2, ACT = 0;

  typedef enum logic [3:0] {IDLE, ADDR, A_ACK, RX, R_ACK, TXL, TX, T_ACK, WAIT} st_t;

  logic [6:0] own_addr;
  logic [8:0] ctrl;
  logic [7:0] tx_data, rx_byte, sh;
  logic       tx_full, tx_empty;
  logic [1:0] scl_s, sda_s;
  logic       scl_p, sda_p, scl_f, sda_f, scl_q, sda_q;
  st_t        st;
  logic [3:0] cnt;
  logic       mack, sda_drv;

  wire run    = ctrl[EN] && !ctrl[SRST];
  wire wr_adr = bus_we && bus_sel == 2'd0;
  wire wr_ctl = bus_we && bus_sel == 2'd1;
  wire wr_tx  = bus_we && bus_sel == 2'd2;

  wire scl_rise = scl_f && !scl_q;
  wire scl_fall = !scl_f && scl_q;
  wire start    = scl_f && scl_q && sda_q && !sda_f;
  wire stop     = scl_f && scl_q && !sda_q && sda_f;
  wire hit      = sh[7:1] == own_addr;
  wire load     = st == TXL && (tx_full || !ctrl[STR]);

  assign scl_oe = run && st == TXL && ctrl[STR];
  assign sda_oe = run && sda_drv;

  always_comb
    case (bus_sel)
      2'd0:    bus_rdata = {9'b0, own_addr};
      2'd1:    bus_rdata = {7'b0, ctrl};
      2'd2:    bus_rdata = {7'b0, tx_empty, rx_byte};
      default: bus_rdata = {8'b0, tx_data};
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_s <= 2'b11; sda_s <= 2'b11;
      scl_p <= 1'b1;  sda_p <= 1'b1;
      scl_f <= 1'b1;  sda_f <= 1'b1;
      scl_q <= 1'b1;  sda_q <= 1'b1;
    end else begin
      scl_s <= {scl_s[0], scl_i};
      sda_s <= {sda_s[0], sda_i};
      scl_p <= scl_s[1];
      sda_p <= sda_s[1];
      if (!ctrl[NF] || scl_s[1] == scl_p) scl_f <= scl_s[1];
      if (!ctrl[NF] || sda_s[1] == sda_p) sda_f <= sda_s[1];
      scl_q <= scl_f;
      sda_q <= sda_f;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      own_addr <= '0; ctrl <= '0; tx_data <= '0;
      tx_full <= 1'b0; tx_empty <= 1'b1;
    end else begin
      if (wr_adr) own_addr <= bus_wdata[6:0];
      if (wr_ctl) ctrl <= bus_wdata[SRST] ? 9'h040 : bus_wdata[8:0];
      if (wr_ctl && bus_wdata[CLR] && !bus_wdata[SRST]) tx_full <= 1'b0;
      else if (load) begin
        tx_full  <= 1'b0;
        tx_empty <= 1'b1;
      end
      if (wr_tx) begin
        tx_data <= bus_wdata[7:0];
        if (!ctrl[CLR]) begin
          tx_full  <= 1'b1;
          tx_empty <= 1'b0;
        end
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= IDLE; cnt <= '0; sh <= '0; rx_byte <= '0; mack <= 1'b0; sda_drv <= 1'b0;
    end else if (!run) begin
      st <= IDLE; sda_drv <= 1'b0;
    end else if (start) begin
      st <= ADDR; cnt <= '0; sda_drv <= 1'b0;
    end else if (stop) begin
      st <= IDLE; sda_drv <= 1'b0;
    end else if (st == TXL) begin
      if (load) begin
        sh <= tx_data; sda_drv <= !tx_data[7]; cnt <= 4'd1; st <= TX;
      end
    end else if (scl_rise) begin
      case (st)
        ADDR, RX: begin sh <= {sh[6:0], sda_f}; cnt <= cnt + 4'd1; end
        T_ACK:    mack <= !sda_f;
        default:  ;
      endcase
    end else if (scl_fall) begin
      case (st)
        ADDR:
          if (cnt == 4'd8) begin
            if (hit && ctrl[ACT]) begin sda_drv <= 1'b1; st <= A_ACK; end
            else st <= WAIT;
          end
        A_ACK: begin sda_drv <= 1'b0; cnt <= '0; st <= sh[0] ? TXL : RX; end
        RX:
          if (cnt == 4'd8) begin
            rx_byte <= sh; sda_drv <= !ctrl[NAKA]; st <= R_ACK;
          end
        R_ACK: begin sda_drv <= 1'b0; cnt <= '0; st <= RX; end
        TX:
          if (cnt == 4'd8) begin sda_drv <= 1'b0; st <= T_ACK; end
          else begin sda_drv <= !sh[6]; sh <= {sh[6:0], 1'b0}; cnt <= cnt + 4'd1; end
        T_ACK: st <= mack ? TXL : WAIT;
        default: ;
      endcase
    end
endmodule

module i2c_slave_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  bus_sel,
  input logic        bus_we,
  input logic [15:0] bus_wdata,
  input logic        scl_oe,
  input logic        sda_oe,
  input logic [8:0]  ctrl,
  input logic        tx_empty
);
  assert_srst_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_sel == 2'd1 && bus_wdata[6]) |=> (!sda_oe && !scl_oe && ctrl == 9'h040));

  assert_off_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[7] |-> (!sda_oe && !scl_oe));

  assert_stretch_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    scl_oe |-> ctrl[3]);

  assert_discard_write_keeps_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_sel == 2'd2 && ctrl[8] && tx_empty) |=> tx_empty);

  assert_normal_write_fills_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_sel == 2'd2 && !ctrl[8]) |=> !tx_empty);
endmodule

bind i2c_slave_port i2c_slave_port_chk u_chk (.*);

// File: tb/tb_i2c_slave_port.sv
module tb_i2c_slave_port;
  logic clk = 0, rst_n = 0;
  logic [1:0] bus_sel = 0;
  logic bus_we = 0;
  logic [15:0] bus_wdata = 0, bus_rdata;
  logic scl_m = 1, sda_m = 1, glitch = 0;
  logic scl_oe, sda_oe;
  wire scl_i = scl_m & ~scl_oe;
  wire sda_i = sda_m & ~sda_oe & ~glitch;
  int n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  i2c_slave_port dut (.clk, .rst_n, .bus_sel, .bus_we, .bus_wdata, .bus_rdata,
                      .scl_i, .sda_i, .scl_oe, .sda_oe);

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [15:0] d);
    @(negedge clk); bus_sel = s; bus_wdata = d; bus_we = 1;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [15:0] d);
    @(negedge clk); bus_sel = s; #1; d = bus_rdata;
  endtask

  task automatic q(); repeat (10) @(negedge clk); endtask

  task automatic m_start(); sda_m = 1; scl_m = 1; q(); sda_m = 0; q(); scl_m = 0; q(); endtask
  task automatic m_stop(); sda_m = 0; q(); scl_m = 1; q(); sda_m = 1; q(); q(); endtask

  task automatic m_bit(input logic b, output logic r);
    sda_m = b; q(); scl_m = 1;
    while (!scl_i) @(negedge clk);
    q(); r = sda_i; scl_m = 0; q();
  endtask

  task automatic m_byte(input logic [7:0] d, output logic nak);
    logic r;
    for (int i = 7; i >= 0; i--) m_bit(d[i], r);
    m_bit(1'b1, nak);
  endtask

  task automatic m_read(input logic nak, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin m_bit(1'b1, r); d[i] = r; end
    m_bit(nak, r);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    rd(0, v); check("R1 addr", v, 16'h0000);
    rd(1, v); check("R1 ctrl", v, 16'h0000);
    rd(2, v); check("R1 status", v, 16'h0100);
    check("R1 lines", {scl_oe, sda_oe}, 2'b00);
  endtask

  task automatic t_regs();
    logic [15:0] v;
    wr(0, 16'hFFFF); rd(0, v); check("R2 addr field", v, 16'h007F);
    wr(1, 16'hFFBF); rd(1, v); check("R2 ctrl field", v, 16'h01BF);
    wr(1, 0); wr(0, 16'h0042);
  endtask

  task automatic t_write();
    logic a; logic [15:0] v;
    wr(1, 16'h0081);
    m_start(); m_byte(8'h84, a); check("R3 match ack", a, 0);
    m_byte(8'h5A, a); check("R6 data ack", a, 0); m_stop();
    rd(2, v); check("R6 rx byte", v[7:0], 8'h5A);
    wr(1, 16'h00A1);
    m_start(); m_byte(8'h84, a); m_byte(8'h33, a); check("R6 nak reply", a, 1); m_stop();
    rd(2, v); check("R6 rx byte nak", v[7:0], 8'h33);
  endtask

  task automatic t_mismatch();
    logic a; logic [15:0] v;
    wr(1, 16'h0081);
    m_start(); m_byte(8'h86, a); check("R3 mismatch nak", a, 1);
    m_byte(8'h77, a); check("R3 ignored data", a, 1); m_stop();
    rd(2, v); check("R3 rx unchanged", v[7:0], 8'h33);
  endtask

  task automatic t_standby_off();
    logic a;
    wr(1, 16'h0080); m_start(); m_byte(8'h84, a); check("R4 standby nak", a, 1); m_stop();
    wr(1, 16'h0001); m_start(); m_byte(8'h84, a); check("R5 disabled nak", a, 1); m_stop();
  endtask

  task automatic t_read();
    logic a; logic [7:0] d; logic [15:0] v;
    wr(1, 16'h0089); wr(2, 16'h00A5);
    rd(2, v); check("R7 empty cleared", v[8], 0);
    m_start(); m_byte(8'h85, a); check("R7 read addr ack", a, 0);
    m_read(1, d); check("R7 byte sent", d, 8'hA5); m_stop();
    rd(2, v); check("R7 empty set", v[8], 1);
  endtask

  task automatic stretched_read(input string req, input logic [7:0] b);
    logic a, r; logic [7:0] d;
    m_start(); m_byte(8'h85, a);
    sda_m = 1; q(); scl_m = 1; repeat (50) @(negedge clk);
    check({req, " scl held"}, scl_i, 0);
    wr(2, {8'h00, b});
    while (!scl_i) @(negedge clk);
    q(); d[7] = sda_i; scl_m = 0; q();
    for (int i = 6; i >= 0; i--) begin m_bit(1'b1, r); d[i] = r; end
    m_bit(1'b1, r); m_stop();
    check({req, " late byte"}, d, b);
  endtask

  task automatic t_stretch();
    wr(1, 16'h0089);
    stretched_read("R8", 8'h3C);
  endtask

  task automatic t_nostretch();
    logic a; logic [7:0] d;
    wr(1, 16'h0081);
    m_start(); m_byte(8'h85, a); m_read(1, d); m_stop();
    check("R9 current contents", d, 8'h3C);
  endtask

  task automatic t_clear();
    logic [15:0] v;
    wr(1, 16'h0089); wr(2, 16'h0011);
    wr(1, 16'h0189); wr(1, 16'h0089);
    stretched_read("R10 stale dropped", 8'h55);
    wr(1, 16'h0189); wr(2, 16'h0066);
    rd(2, v); check("R10 write in discard", v[8], 1);
    wr(1, 16'h0089);
    rd(2, v); check("R10 leave discard", v[8], 1);
    wr(2, 16'h0077);
    rd(2, v); check("R10 normal write", v[8], 0);
  endtask

  task automatic t_srst();
    logic a; logic [15:0] v;
    wr(1, 16'h00BF); wr(1, 16'h00FF);
    rd(1, v); check("R11 ctrl kept only srst", v, 16'h0040);
    m_start(); m_byte(8'h84, a); check("R11 held no ack", a, 1); m_stop();
    wr(1, 0);
    rd(1, v); check("R11 released", v, 16'h0000);
    rd(0, v); check("R11 addr kept", v, 16'h0042);
  endtask

  task automatic glitch_xfer(input logic [15:0] c, output logic a);
    logic r;
    wr(1, c);
    m_start(); m_byte(8'h84, a);
    sda_m = 1; q(); scl_m = 1; repeat (5) @(negedge clk);
    glitch = 1; @(negedge clk); glitch = 0;
    repeat (5) @(negedge clk); scl_m = 0; q();
    for (int i = 6; i >= 0; i--) m_bit(1'b1, r);
    m_bit(1'b1, a); m_stop();
  endtask

  task automatic t_filter();
    logic a; logic [15:0] v;
    glitch_xfer(16'h0085, a); check("R12 filtered ack", a, 0);
    rd(2, v); check("R12 filtered byte", v[7:0], 8'hFF);
    glitch_xfer(16'h0081, a); check("R12 unfiltered abort", a, 1);
  endtask

  task automatic t_master_nak();
    logic a; logic [7:0] d;
    wr(1, 16'h0081);
    m_start(); m_byte(8'h85, a); m_read(1, d);
    check("R13 byte", d, 8'h77);
    m_read(1, d); check("R13 released", d, 8'hFF); m_stop();
    m_start(); m_byte(8'h84, a); check("R13 next start", a, 0); m_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk); rst_n = 1; @(negedge clk);
    t_reset(); t_regs(); t_write(); t_mismatch(); t_standby_off();
    t_read(); t_stretch(); t_nostretch(); t_clear(); t_srst();
    t_filter(); t_master_nak();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule